// File: doc/BRIEF.md
# Reset Cause Capture Register

This block sits beside a chip's reset tree and records which events led to the most recent reset. It accepts four requests: a power-on reset, a watchdog overflow pulse, an active-low external reset pin and a software reset pulse. It merges the three run-time requests into a single stretched internal reset. It also keeps one sticky flag per cause, which software reads through a single-register read port.

The same 8-bit register carries three write-only watchdog control bits: an enable and a two-bit interval select. The block stores them and drives them out to the watchdog counter. Any internal reset returns them to all ones. Reading the register clears the cause flags. No other event removes a flag, so a burst of resets accumulates flags until software looks at them.

The power-on input is an asynchronous active-low reset whose release is synchronized internally. It is the only thing that resets the cause flags, and it leaves them at a fixed value with only the power-on flag set.

Top module: `rst_cause_reg`

## Requirements
- R1: After power-on release and the reset stretch, the read port shows 0x80: only the power-on flag is set. The watchdog enable and select outputs are all 1, and `rst_n_o` is high.
- R2: Read data layout is fixed. Bit 7 is the power-on flag, bit 5 the watchdog flag, bit 4 the external flag and bit 3 the software flag. Bit 6 and bits 2..0 always read 0.
- R3: A watchdog overflow pulse sets bit 5, and a software reset pulse sets bit 3, at the clock edge that samples the pulse.
- R4: Causes that reach the flag logic in the same cycle set every matching flag together.
- R5: A set flag stays 1 when a different cause arrives later. A run-time reset never clears a flag.
- R6: A read cycle returns the flags held before the read. The flags are cleared at the edge that ends that read cycle, so a second read returns 0.
- R7: A cause that arrives in the same cycle as a read is kept: its flag is 1 after the clear.
- R8: The external pin passes through a two-stage synchronizer. A one-cycle low on the pin sets bit 4 three clock edges after the pin is first sampled low, and no earlier.
- R9: After the last cause is seen, `rst_n_o` stays low for exactly 4 clock cycles (parameter `STRETCH_CYC`).
- R10: A write while `rst_n_o` is high loads `wdata_i[2]` into the enable output and `wdata_i[1:0]` into the select output. These bits are not visible on the read port.
- R11: While the internal reset is active, the enable and select outputs are forced to all ones. A write during that time has no effect.
- R12: A new power-on reset returns the read port to 0x80, whatever flags were set before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| wdog_ovf_i | input | 1 | Watchdog overflow request, one-cycle pulse |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset request, one-cycle pulse |
| rd_i | input | 1 | Register read strobe; clears the cause flags |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 3 | Write data for the watchdog control bits |
| rdata_o | output | 8 | Register read data |
| rst_n_o | output | 1 | Merged, stretched internal reset, active low |
| wd_en_o | output | 1 | Watchdog enable |
| wd_sel_o | output | 2 | Watchdog interval select |

## Verification
The bench sweeps every pair of earlier and later cause combinations. It feeds the pin two cycles ahead of the pulses so that all three causes land together. A design that replaced flags instead of OR-ing them, or that dropped one of a simultaneous pair, returns a smaller value than the union. Reads that coincide with a new cause are checked, because a clear that took priority over the set would lose that cause. The synchronizer delay and the exact stretch length are counted edge by edge. Writes are made during the stretch, where a design that ignored the internal reset would keep the written control value.

// File: rtl/rst_cause_pkg.sv
`timescale 1ns/1ps
package rst_cause_pkg;
  // read-data bit positions (software decodes these)
  localparam int BIT_PON = 7;
  localparam int BIT_WDG = 5;
  localparam int BIT_EXT = 4;
  localparam int BIT_SW  = 3;
  localparam int REG_W   = 8;
  localparam int CTL_W   = 3;
  localparam logic [CTL_W-1:0] CTL_RST_VAL = 3'b111;

  typedef struct packed {
    logic wdg;
    logic ext;
    logic sw;
  } cause_t;
endpackage

// File: rtl/rst_cause_sync.sv
`timescale 1ns/1ps
module rst_cause_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= {STAGES{RST_VAL}};
    else           chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_cause_stretch.sv
`timescale 1ns/1ps
module rst_cause_stretch #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    cnt_d  = trig_i ? LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)   cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rst_cause_flags.sv
`timescale 1ns/1ps
module rst_cause_flags
  import rst_cause_pkg::*;
(
  input  logic   clk_i,
  input  logic   arst_n_i,
  input  cause_t ev_i,
  input  logic   clr_i,
  output logic   pon_o,
  output cause_t cause_o
);
  cause_t cause_q, cause_d;
  logic   pon_q, pon_d;
  logic   upd_en;

  always_comb begin
    upd_en  = clr_i || (ev_i != '0);
    // clear first, then OR in new causes so a same-cycle cause survives
    cause_d = (clr_i ? cause_t'('0) : cause_q) | ev_i;
    pon_d   = clr_i ? 1'b0 : pon_q;
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      cause_q <= '0;
      pon_q   <= 1'b1;
    end else if (upd_en) begin
      cause_q <= cause_d;
      pon_q   <= pon_d;
    end
  end

  assign pon_o   = pon_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_CYC = 4
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic             wdog_ovf_i,
  input  logic             ext_rst_n_i,
  input  logic             sw_rst_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             rst_n_o,
  output logic             wd_en_o,
  output logic [1:0]       wd_sel_o
);
  logic             por_sync_n;
  logic             ext_pin_s;
  cause_t           ev;
  logic             ev_any;
  logic             int_rst;
  logic             pon_flag;
  cause_t           cause_flags;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             ctl_en;

  // power-on: asynchronous assert, synchronized release
  rst_cause_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_por_sync (
    .clk_i(clk_i), .arst_n_i(por_n_i), .d_i(1'b1), .q_o(por_sync_n)
  );

  // external pin synchronizer, idles high
  rst_cause_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ext_sync (
    .clk_i(clk_i), .arst_n_i(por_n_i), .d_i(ext_rst_n_i), .q_o(ext_pin_s)
  );

  always_comb begin
    ev.wdg = wdog_ovf_i;
    ev.ext = ~ext_pin_s;
    ev.sw  = sw_rst_i;
    ev_any = (ev != '0);
  end

  rst_cause_stretch #(.CYCLES(STRETCH_CYC)) i_stretch (
    .clk_i(clk_i), .arst_n_i(por_sync_n), .trig_i(ev_any), .active_o(int_rst)
  );

  rst_cause_flags i_flags (
    .clk_i(clk_i), .arst_n_i(por_sync_n), .ev_i(ev), .clr_i(rd_i),
    .pon_o(pon_flag), .cause_o(cause_flags)
  );

  // watchdog control bits
  always_comb begin
    ctl_en = int_rst || wr_i;
    ctl_d  = int_rst ? CTL_RST_VAL : wdata_i;
  end

  always_ff @(posedge clk_i or negedge por_sync_n) begin
    if (!por_sync_n)  ctl_q <= CTL_RST_VAL;
    else if (ctl_en)  ctl_q <= ctl_d;
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[BIT_PON] = pon_flag;
    rdata_o[BIT_WDG] = cause_flags.wdg;
    rdata_o[BIT_EXT] = cause_flags.ext;
    rdata_o[BIT_SW]  = cause_flags.sw;
  end

  assign rst_n_o  = ~int_rst;
  assign wd_en_o  = ctl_q[2];
  assign wd_sel_o = ctl_q[1:0];
endmodule

module rst_cause_chk (
  input logic       clk_i,
  input logic       por_sync_n,
  input logic       ev_any,
  input logic       rd_i,
  input logic       wdog_ovf_i,
  input logic       sw_rst_i,
  input logic [7:0] rdata_o,
  input logic       rst_n_o,
  input logic       wd_en_o,
  input logic [1:0] wd_sel_o
);
  p_wdg_sets_r3: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    wdog_ovf_i |=> rdata_o[5]);
  p_sw_sets_r3: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    sw_rst_i |=> rdata_o[3]);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    !rd_i |=> ((rdata_o[5:3] & $past(rdata_o[5:3])) == $past(rdata_o[5:3])));
  p_pon_clear_r6: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    rd_i |=> !rdata_o[7]);
  p_keep_on_read_r7: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    (rd_i && sw_rst_i) |=> rdata_o[3]);
  p_stretch_r9: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    ev_any |=> !rst_n_o);
  p_ctl_forced_r11: assert property (@(posedge clk_i) disable iff (!por_sync_n)
    !rst_n_o |=> ({wd_en_o, wd_sel_o} == 3'b111));
endmodule

bind rst_cause_reg rst_cause_chk i_chk (
  .clk_i(clk_i), .por_sync_n(por_sync_n), .ev_any(ev_any), .rd_i(rd_i),
  .wdog_ovf_i(wdog_ovf_i), .sw_rst_i(sw_rst_i), .rdata_o(rdata_o),
  .rst_n_o(rst_n_o), .wd_en_o(wd_en_o), .wd_sel_o(wd_sel_o)
);

// File: tb/test_rst_cause_reg.sv
`timescale 1ns/1ps
module test_rst_cause_reg;
  logic       clk_i = 1'b0;
  logic       por_n_i, wdog_ovf_i, ext_rst_n_i, sw_rst_i, rd_i, wr_i;
  logic [2:0] wdata_i;
  logic [7:0] rdata_o;
  logic       rst_n_o, wd_en_o;
  logic [1:0] wd_sel_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rst_cause_reg i_rst_cause_reg (
    .clk_i(clk_i), .por_n_i(por_n_i), .wdog_ovf_i(wdog_ovf_i),
    .ext_rst_n_i(ext_rst_n_i), .sw_rst_i(sw_rst_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_n_o(rst_n_o),
    .wd_en_o(wd_en_o), .wd_sel_o(wd_sel_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // b = {wdg, ext, sw}; the pin goes two cycles early so all land together
  task automatic apply(input logic [2:0] b);
    ext_rst_n_i = ~b[1];
    @(negedge clk_i); ext_rst_n_i = 1'b1;
    @(negedge clk_i); wdog_ovf_i = b[2]; sw_rst_i = b[0];
    @(negedge clk_i); wdog_ovf_i = 1'b0; sw_rst_i = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic power_on();
    por_n_i = 1'b0;
    cycles(3);
    por_n_i = 1'b1;
    cycles(10);
  endtask

  initial begin
    logic [7:0] v;
    int lows;
    por_n_i = 1'b0; wdog_ovf_i = 1'b0; ext_rst_n_i = 1'b1; sw_rst_i = 1'b0;
    rd_i = 1'b0; wr_i = 1'b0; wdata_i = 3'b000;
    @(negedge clk_i);
    power_on();

    // R1: reset state
    check("R1 rdata", rdata_o, 8'h80);
    check("R1 ctl", {5'b0, wd_en_o, wd_sel_o}, 8'h07);
    check("R1 rst_n_o", {7'b0, rst_n_o}, 8'h01);

    // R6: read returns pre-clear value, second read sees zero
    do_read(v); check("R6 first read", v, 8'h80);
    do_read(v); check("R6 second read", v, 8'h00);

    // R10: write control bits while not in reset
    wr_i = 1'b1; wdata_i = 3'b010;
    @(negedge clk_i); wr_i = 1'b0;
    check("R10 ctl", {5'b0, wd_en_o, wd_sel_o}, 8'h02);
    check("R10 readback", rdata_o, 8'h00);

    // R3 and R9: software pulse, count stretch length
    apply(3'b001);
    check("R3 sw flag", rdata_o, 8'h08);
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      if (!rst_n_o) lows++;
      // R11: write during reset is ignored
      if (i == 1) wr_i = 1'b1;
      if (i == 1) wdata_i = 3'b000;
      if (i == 2) wr_i = 1'b0;
      @(negedge clk_i);
    end
    check("R9 stretch length", 8'(lows), 8'd4);
    check("R11 ctl after reset", {5'b0, wd_en_o, wd_sel_o}, 8'h07);

    // R3: watchdog pulse
    do_read(v);
    apply(3'b100); cycles(6);
    check("R3 wdg flag", rdata_o, 8'h20);

    // R7: cause in the read cycle survives the clear
    do_read(v);
    rd_i = 1'b1; sw_rst_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i); rd_i = 1'b0; sw_rst_i = 1'b0;
    check("R7 pre-read value", v, 8'h00);
    check("R7 kept flag", rdata_o, 8'h08);
    cycles(6);

    // R8: synchronizer latency
    do_read(v);
    ext_rst_n_i = 1'b0;
    @(negedge clk_i); ext_rst_n_i = 1'b1;
    @(negedge clk_i);
    check("R8 not yet", rdata_o, 8'h00);
    @(negedge clk_i);
    check("R8 set", rdata_o, 8'h10);
    cycles(6);

    // R2, R4, R5: sweep of earlier and later cause sets
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) begin
        logic [2:0] u;
        do_read(v);
        apply(3'(p)); cycles(6);
        apply(3'(n)); cycles(6);
        u = 3'(p) | 3'(n);
        check("R4/R5/R2 sweep", rdata_o, {2'b00, u, 3'b000});
      end
    end

    // R12: power-on overrides accumulated flags
    apply(3'b111); cycles(6);
    power_on();
    check("R12 rdata", rdata_o, 8'h80);
    check("R12 ctl", {5'b0, wd_en_o, wd_sel_o}, 8'h07);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule